// File: doc/BRIEF.md
# Serial DAC Word Transmitter

This block turns a stream of parallel 20-bit two's complement samples into the three-wire serial format that a sign-magnitude audio DAC expects: a bit clock, a data line and a latch-enable line. Samples arrive through a valid/ready handshake. Each one is sent in a frame of 24 bit periods. The frame starts with 4 copies of the sign bit, then carries the 20 data bits with the most significant bit first. The least significant bit is the last bit before latch enable goes low.

The block runs on the system clock and is paced by `tick_i`. Every tick moves the generated bit clock half a period, so one bit period takes two ticks. Holding `tick_i` high gives a bit clock at half the system clock rate. Dropping `tick_i` freezes every output, which stops the bit clock. The data line and latch enable change only on falling edges of the bit clock, so they are stable at every rising edge, where the DAC samples. Latch enable is low for exactly one bit period, slot 0 of each frame, and high for the other 23 slots. If the source has no sample ready when a frame ends, the previous sample is sent again.

The state machine has four states. `ST_IDLE` is entered at reset and is left on the first tick (transition *start*). `ST_LATCH` covers slot 0, with latch enable low and a sign pad bit on the line. It moves to `ST_PAD` on *pad_go* at the end of slot 0. `ST_PAD` covers the remaining pad slots and moves to `ST_DATA` on *data_go* after the last pad slot. `ST_DATA` covers slots 4 to 23. After slot 23 it returns to `ST_LATCH` on *wrap*, and that is the point where the next sample is loaded.

Top module: `dac_word_tx`

## Requirements
- R1: While reset is asserted, and until the first tick after reset, `dac_sclk_o` is 0, `dac_le_o` is 1 and `dac_sdo_o` is 0. `s_ready_o` is 0 whenever `tick_i` is 0.
- R2: Every tick outside `ST_IDLE` toggles `dac_sclk_o`. One bit slot is two ticks long: low first, then high. A frame is 24 slots, numbered 0 to 23.
- R3: `dac_sdo_o` and `dac_le_o` change only in the same cycle as a falling edge of `dac_sclk_o`, or on the first tick after reset. They never change at a rising edge.
- R4: In slots 0 to 3, `dac_sdo_o` carries the sign bit (bit 19) of the frame's word. In slot n, for n from 4 to 23, it carries word bit 23−n, so bit 19 goes first and bit 0 goes last.
- R5: `dac_le_o` is 0 during slot 0 and 1 during slots 1 to 23. It therefore stays high for at least one bit period before it falls, and stays low across exactly one rising edge.
- R6: `s_ready_o` is 1 only in the tick that ends slot 23, or in the first tick after reset. A sample accepted there (`s_valid_i` and `s_ready_o` both 1) is the word of the frame that starts next.
- R7: If `s_valid_i` is 0 when `s_ready_o` is 1, the next frame repeats the previous word. The first word after reset is 0.
- R8: In a cycle where `tick_i` is 0, all three DAC outputs hold their values. This includes holding `dac_le_o` low when the clock stops in slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Half-bit-period enable |
| s_valid_i | input | 1 | Sample valid |
| s_ready_o | output | 1 | Sample accepted this cycle when valid |
| s_data_i | input | 20 | Two's complement sample |
| dac_sclk_o | output | 1 | Bit clock to the DAC |
| dac_sdo_o | output | 1 | Serial data to the DAC |
| dac_le_o | output | 1 | Latch enable to the DAC |

## Verification
The hardest case to reach from the ports is a stopped bit clock while latch enable is low. `tick_i` has to stay low for a long stretch in exactly the slot-0 window, right after a new word has been loaded. The bench tracks the frame position in its model, and once the run has left its steady-clock phase it withholds ticks for a dozen cycles whenever the model sits in slot 0 of an odd frame. Outside those stops, ticks come from a pseudo-random pattern. Sample gaps are tied to frame numbers so that repeated words appear, and extreme codes such as 80000h and 7FFFFh are sent early.

// File: rtl/dac_tx_pkg.sv
`timescale 1ns/1ps
package dac_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LATCH = 2'd1,
        ST_PAD   = 2'd2,
        ST_DATA  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/dac_tx_seq.sv
`timescale 1ns/1ps
module dac_tx_seq
    import dac_tx_pkg::*;
#(
    parameter int DATA_W    = 20,
    parameter int FRAME_LEN = 24,
    parameter int IDX_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output tx_state_e        state_o,
    output logic [IDX_W-1:0] slot_o,
    output logic [IDX_W-1:0] slot_nxt_o,
    output logic             phase_o,
    output logic             adv_o,
    output logic             load_o
);
    localparam int PAD_LEN = FRAME_LEN - DATA_W;
    localparam logic [IDX_W-1:0] SLOT_LAST   = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] SLOT_PADEND = IDX_W'(PAD_LEN - 1);
    localparam tx_state_e AFTER_LATCH = (PAD_LEN > 1) ? ST_PAD : ST_DATA;

    tx_state_e        st_q, st_d;
    logic [IDX_W-1:0] slot_q, slot_d;
    logic             phase_q, phase_d;
    logic             adv, load;

    always_comb begin
        adv    = tick_i && ((st_q == ST_IDLE) || phase_q);
        load   = tick_i && ((st_q == ST_IDLE) || (phase_q && slot_q == SLOT_LAST));
        slot_d = ((st_q == ST_IDLE) || (slot_q == SLOT_LAST)) ? '0 : slot_q + 1'b1;
        phase_d = (tick_i && st_q != ST_IDLE) ? ~phase_q : phase_q;
        st_d   = st_q;
        unique case (st_q)
            ST_IDLE:  if (tick_i) st_d = ST_LATCH;
            ST_LATCH: if (adv) st_d = AFTER_LATCH;
            ST_PAD:   if (adv && slot_q == SLOT_PADEND) st_d = ST_DATA;
            ST_DATA:  if (adv && slot_q == SLOT_LAST) st_d = ST_LATCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            slot_q  <= '0;
            phase_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            phase_q <= phase_d;
            if (adv) slot_q <= slot_d;
        end
    end

    assign state_o    = st_q;
    assign slot_o     = slot_q;
    assign slot_nxt_o = slot_d;
    assign phase_o    = phase_q;
    assign adv_o      = adv;
    assign load_o     = load;

    // R2: the slot index never leaves the frame
    assert_slot_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= SLOT_LAST);
    // R5: the latch state always sits on slot 0
    assert_latch_on_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCH) |-> (slot_q == '0));
    // R4: data state only covers the data slots
    assert_data_after_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA) |-> (int'(slot_q) >= PAD_LEN));
    // R1: the bit clock stays low while idle
    assert_idle_clock_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !phase_q);
endmodule

// File: rtl/dac_tx_hold.sv
`timescale 1ns/1ps
module dac_tx_hold #(
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] word_nxt_o
);
    logic [DATA_W-1:0] word_q;
    logic              take;

    always_comb begin
        take       = load_i && valid_i;
        word_nxt_o = take ? data_i : word_q;
        ready_o    = load_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_nxt_o;
    end

    // R7: a frame boundary without a sample keeps the old word
    assert_repeat_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !valid_i) |=> $stable(word_q));
endmodule

// File: rtl/dac_tx_bitsel.sv
`timescale 1ns/1ps
module dac_tx_bitsel #(
    parameter int DATA_W    = 20,
    parameter int FRAME_LEN = 24,
    parameter int IDX_W     = $clog2(FRAME_LEN)
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [IDX_W-1:0]  slot_i,
    output logic              bit_o
);
    localparam int PAD_LEN = FRAME_LEN - DATA_W;

    always_comb begin
        int pos;
        pos = FRAME_LEN - 1 - int'(slot_i);
        if (int'(slot_i) < PAD_LEN || pos < 0 || pos >= DATA_W) bit_o = word_i[DATA_W-1];
        else bit_o = word_i[pos];
    end
endmodule

// File: rtl/dac_word_tx.sv
`timescale 1ns/1ps
module dac_word_tx
    import dac_tx_pkg::*;
#(
    parameter int DATA_W    = 20,
    parameter int FRAME_LEN = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              s_valid_i,
    output logic              s_ready_o,
    input  logic [DATA_W-1:0] s_data_i,
    output logic              dac_sclk_o,
    output logic              dac_sdo_o,
    output logic              dac_le_o
);
    localparam int IDX_W = $clog2(FRAME_LEN);

    tx_state_e         st;
    logic [IDX_W-1:0]  slot, slot_nxt;
    logic              phase, adv, load, bit_nxt;
    logic [DATA_W-1:0] word_nxt;

    dac_tx_seq #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .state_o(st), .slot_o(slot), .slot_nxt_o(slot_nxt),
        .phase_o(phase), .adv_o(adv), .load_o(load)
    );

    dac_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load_i(load), .valid_i(s_valid_i),
        .data_i(s_data_i), .ready_o(s_ready_o), .word_nxt_o(word_nxt)
    );

    dac_tx_bitsel #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_sel (
        .word_i(word_nxt), .slot_i(slot_nxt), .bit_o(bit_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_sdo_o <= 1'b0;
            dac_le_o  <= 1'b1;
        end else if (adv) begin
            dac_sdo_o <= bit_nxt;
            dac_le_o  <= (slot_nxt != '0);
        end
    end

    assign dac_sclk_o = phase;

    // R3: nothing moves at a rising bit-clock edge
    assert_rise_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk_o) |-> ($stable(dac_sdo_o) && $stable(dac_le_o)));
    // R3: latch enable moves only with a falling edge, apart from leaving idle
    assert_le_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_le_o) && $past(st) != ST_IDLE) |-> $fell(dac_sclk_o));
    // R5: latch enable rises only after a rising edge was seen while it was low
    assert_le_low_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_le_o) |-> $past(dac_sclk_o));
    // R6: latch enable falls only right after a load point
    assert_le_fall_at_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_le_o) |-> $past(s_ready_o));
    // R8: a missing tick freezes the DAC lines
    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_i) |-> ($stable(dac_sclk_o) && $stable(dac_sdo_o) && $stable(dac_le_o)));
endmodule

// File: tb/sim_dac_word_tx.sv
`timescale 1ns/1ps
module sim_dac_word_tx;
    logic        clk = 1'b0;
    logic        rst_n, tick_i, s_valid_i;
    logic [19:0] s_data_i;
    logic        s_ready_o, dac_sclk_o, dac_sdo_o, dac_le_o;

    always #10 clk = ~clk;

    dac_word_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .s_valid_i(s_valid_i), .s_ready_o(s_ready_o), .s_data_i(s_data_i),
        .dac_sclk_o(dac_sclk_o), .dac_sdo_o(dac_sdo_o), .dac_le_o(dac_le_o)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [19:0] samp(input int i);
        case (i)
            0: return 20'h12345;
            1: return 20'h80000;
            2: return 20'h7FFFF;
            3: return 20'h00001;
            4: return 20'hFFFFF;
            5: return 20'h00000;
            default: return 20'((i * 32'h3A5C7) ^ 32'h5A5A5);
        endcase
    endfunction

    function automatic int exp_bit(input logic [19:0] w, input int slot);
        if (slot < 4) return int'(w[19]);
        return int'(w[23 - slot]);
    endfunction

    localparam int N_SAMP = 30;
    localparam int N_FRAMES = 30;

    // behavioural model state
    bit          started = 0;
    int          h = 0;
    logic [19:0] mw = '0;
    bit          rep = 0;
    int          frames = 0;
    int          k = 0;
    int          hold = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit          xfer = 0;
    logic [19:0] cap = '0;
    bit          prev_tick = 0;
    logic        prev_sclk = 0, prev_sdo = 0, prev_le = 1;
    int          cyc = 0;
    bit          timeout = 0;

    initial begin
        rst_n = 1'b0; tick_i = 1'b0; s_valid_i = 1'b0; s_data_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "sclk in reset", int'(dac_sclk_o), 0);
        chk("R1", "le in reset", int'(dac_le_o), 1);
        chk("R1", "sdo in reset", int'(dac_sdo_o), 0);
        chk("R1", "ready without tick", int'(s_ready_o), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        while (frames < N_FRAMES && !timeout) begin
            @(negedge clk);
            begin
                int slot;
                slot = h / 2;
                chk("R2", "sclk", int'(dac_sclk_o), (started && (h % 2 == 1)) ? 1 : 0);
                chk("R5", "le", int'(dac_le_o), !started ? 1 : ((slot != 0) ? 1 : 0));
                chk(rep ? "R7" : "R4", "sdo", int'(dac_sdo_o),
                    !started ? 0 : exp_bit(mw, slot));
                chk("R6", "ready", int'(s_ready_o),
                    (tick_i && (!started || h == 47)) ? 1 : 0);
                if (dac_sclk_o && !prev_sclk) begin
                    chk("R3", "sdo at rise", int'(dac_sdo_o), int'(prev_sdo));
                    chk("R3", "le at rise", int'(dac_le_o), int'(prev_le));
                end
                if (!prev_tick) begin
                    chk("R8", "sclk frozen", int'(dac_sclk_o), int'(prev_sclk));
                    chk("R8", "sdo frozen", int'(dac_sdo_o), int'(prev_sdo));
                    chk("R8", "le frozen", int'(dac_le_o), int'(prev_le));
                end
                prev_sclk = dac_sclk_o; prev_sdo = dac_sdo_o; prev_le = dac_le_o;
                xfer = s_valid_i && s_ready_o;
                cap  = s_data_i;
            end

            @(posedge clk);
            prev_tick = tick_i;
            if (tick_i) begin
                bit ld;
                ld = 0;
                if (!started) begin
                    started = 1; h = 0; ld = 1;
                end else begin
                    h++;
                    if (h == 48) begin h = 0; ld = 1; end
                end
                if (ld) begin
                    if (xfer) begin mw = cap; rep = 0; k++; end
                    else rep = 1;
                    frames++;
                    if (frames % 2 == 1) hold = 12;
                end
            end

            #1;
            if (frames < 8) tick_i = 1'b1;
            else if (started && h == 0 && hold > 0) begin
                tick_i = 1'b0; hold--;
            end else begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                tick_i = lfsr[0] | lfsr[1];
            end
            s_valid_i = (k < N_SAMP) && (frames % 4 != 2);
            s_data_i  = samp(k);
            cyc++;
            if (cyc > 100000) begin
                timeout = 1;
                n_cmp++; n_bad++;
                $display("FAIL R2 watchdog: actual %0d cycles expected at most 100000", cyc);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule